// File: doc/BRIEF.md
# Dual-Channel Register Access Decoder

This block connects a parallel host bus to two identical register banks, channel A and channel B. An active-low select input enables a bus access, and a channel-pick input chooses which bank a read or write reaches. Each channel holds eight 8-bit registers addressed by the low three address bits. A single shared control register sits at its own address outside both banks.

Bit 0 of the shared control register switches on broadcast writes. While it is set, a write to a bank register ignores the channel-pick input and stores the same byte into both channels on one clock edge, so both channels can be set up with one bus cycle. Reads are never broadcast: they always return the bank chosen by channel-pick. Read data is a combinational mux of the addressed register, paired with a drive-enable flag. A registered valid flag follows each accepted read by one cycle.

Top module: `dca_top`

## Requirements
- R1: While selN is 1, no register changes on any write, rdDrive is 0 and rdData is 0.
- R2: With selN 0 and chanPick 1, a bank access (addr[3] = 0) reads or writes channel A register addr[2:0].
- R3: With selN 0 and chanPick 0, a bank access reads or writes channel B register addr[2:0].
- R4: When bit 0 of the shared control register is 1, a bank write stores wrData into register addr[2:0] of both channels on the same clock edge, whatever chanPick is.
- R5: Broadcast mode leaves reads unchanged: a bank read returns the channel chosen by chanPick.
- R6: The shared control register sits at address 8 (4'b1000); reads return its value with either chanPick, and a write to it changes only that register. Addresses 9 to 15 read as 0 and writes to them change nothing.
- R7: After reset all bank registers and the shared control register are 0, so broadcast is off.
- R8: rdValid is 1 in the cycle after a clock edge at which a read was accepted (selN 0, rdEn 1, wrEn 0), and 0 otherwise.
- R9: When wrEn and rdEn are both 1, the write takes place, rdDrive stays 0, rdData is 0 and no rdValid follows.
- R10: A write takes effect at the clock edge where wrEn is sampled; a read in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selN | input | 1 | Active-low access enable |
| chanPick | input | 1 | 1 selects channel A, 0 selects channel B |
| addr | input | 4 | Register address; bit 3 set selects the shared space |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data, 0 when not driven |
| rdDrive | output | 1 | Read data is valid this cycle |
| rdValid | output | 1 | Registered flag, one cycle after an accepted read |

## Verification
Read data and rdDrive are combinational, so the bench checks them in the same cycle the strobes are driven, one nanosecond after the falling edge and well before the rising edge. A write lands at the next rising edge, so its effect is checked by a read in a following cycle, and rdValid is checked at the falling edge after that rising edge. Every cycle of constrained random traffic compares all three outputs against a bench model that updates only at the rising edge.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrAf;
    logic rdA;
    logic rdB;
    logic rdAf;
    logic rdAny;
  } ctrlStrobes_t;
endpackage

// File: rtl/dca_ctrl.sv
module dca_ctrl
  import dca_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              chanPick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW:0]   addr,
  input  logic              bcastOn,
  output ctrlStrobes_t      strobes,
  output logic              rdValid
);
  localparam logic [REG_AW:0] AF_ADDR = (REG_AW+1)'(1) << REG_AW;

  logic isWr, isRd, inBank, isAf;

  always_comb begin
    isWr   = !selN && wrEn;
    isRd   = !selN && rdEn && !wrEn;
    inBank = !addr[REG_AW];
    isAf   = (addr == AF_ADDR);
    strobes.wrA   = isWr && inBank && (chanPick || bcastOn);
    strobes.wrB   = isWr && inBank && (!chanPick || bcastOn);
    strobes.wrAf  = isWr && isAf;
    strobes.rdA   = isRd && inBank && chanPick;
    strobes.rdB   = isRd && inBank && !chanPick;
    strobes.rdAf  = isRd && isAf;
    strobes.rdAny = isRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= isRd;
  end

  // R8: valid flag follows an accepted read by one cycle
  assert_valid_lag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && rdEn && !wrEn) |=> rdValid);
  // R9: a colliding read never produces a valid flag
  assert_no_valid_on_clash_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |=> !rdValid);
  // R5: at most one read source per cycle
  assert_read_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdA, strobes.rdB, strobes.rdAf}));
endmodule

// File: rtl/dca_datapath.sv
module dca_datapath
  import dca_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [REG_AW-1:0] idx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              bcastOn
);
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int NUM_CH   = 2;

  logic [NUM_CH-1:0] wrSel;
  logic [DATA_W-1:0] afReg;
  logic [DATA_W-1:0] chanOut [NUM_CH];

  assign wrSel   = {strobes.wrB, strobes.wrA};
  assign bcastOn = afReg[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : gBank
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    always_ff @(posedge clk) begin
      if (!rstN)         regs <= '0;
      else if (wrSel[c]) regs[idx] <= wrData;
    end
    assign chanOut[c] = regs[idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             afReg <= '0;
    else if (strobes.wrAf) afReg <= wrData;
  end

  always_comb begin
    rdDrive = strobes.rdAny;
    rdData  = '0;
    if (strobes.rdA)       rdData = chanOut[0];
    else if (strobes.rdB)  rdData = chanOut[1];
    else if (strobes.rdAf) rdData = afReg;
  end

  // R4: a dual write leaves both channels equal at that register
  assert_bcast_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrA && strobes.wrB) |=>
      (gBank[0].regs[$past(idx)] == gBank[1].regs[$past(idx)]));
  // R1: without a write strobe no storage moves
  assert_no_stray_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrA || strobes.wrB || strobes.wrAf) |=>
      ($stable(gBank[0].regs) && $stable(gBank[1].regs) && $stable(afReg)));
endmodule

// File: rtl/dca_top.sv
module dca_top
  import dca_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       chanPick,
  input  logic [3:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       rdDrive,
  output logic       rdValid
);
  localparam int DATA_W = 8;
  localparam int REG_AW = 3;

  ctrlStrobes_t strobes;
  logic         bcastOn;

  dca_ctrl #(.REG_AW(REG_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .selN(selN), .chanPick(chanPick),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .bcastOn(bcastOn),
    .strobes(strobes), .rdValid(rdValid)
  );

  dca_datapath #(.DATA_W(DATA_W), .REG_AW(REG_AW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .idx(addr[REG_AW-1:0]),
    .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive), .bcastOn(bcastOn)
  );

  // R1: an idle bus sees no driven data
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> (!rdDrive && rdData == 8'h00));
  // R9: write wins over read
  assert_wr_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |-> !rdDrive);
endmodule

// File: tb/sim_dca_top.sv
module sim_dca_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, chanPick = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rdDrive, rdValid;

  int total = 0;
  int bad = 0;
  logic [7:0] mA [8];
  logic [7:0] mB [8];
  logic [7:0] mAf;
  logic expValid = 1'b0;

  always #2 clk = ~clk;

  dca_top u0 (.clk(clk), .rstN(rstN), .selN(selN), .chanPick(chanPick),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive), .rdValid(rdValid));

  function automatic logic [7:0] expRead(logic s, logic ch, logic [3:0] a, logic w, logic r);
    if (s || !r || w) return 8'h00;
    if (a == 4'd8) return mAf;
    if (a[3]) return 8'h00;
    return ch ? mA[a[2:0]] : mB[a[2:0]];
  endfunction

  function automatic string tagOf(logic s, logic ch, logic [3:0] a, logic w, logic r);
    if (s) return "R1";
    if (w && r) return "R9";
    if (a[3]) return "R6";
    if (mAf[0]) return "R5";
    return ch ? "R2" : "R3";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: caller is at a falling edge
  task automatic busCycle(logic s, logic ch, logic [3:0] a, logic w, logic r, logic [7:0] d);
    logic [7:0] ed;
    string t;
    selN = s; chanPick = ch; addr = a; wrEn = w; rdEn = r; wrData = d;
    #1;
    t  = tagOf(s, ch, a, w, r);
    ed = expRead(s, ch, a, w, r);
    check(t, rdData, ed);
    check(t, {7'd0, rdDrive}, {7'd0, (!s && r && !w)});
    @(posedge clk);
    if (!s && w) begin
      if (a == 4'd8) mAf = d;
      else if (!a[3]) begin
        if (mAf[0] || ch)  mA[a[2:0]] = d;
        if (mAf[0] || !ch) mB[a[2:0]] = d;
      end
    end
    expValid = !s && r && !w;
    @(negedge clk);
    check("R8", {7'd0, rdValid}, {7'd0, expValid});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 8; i++) begin mA[i] = '0; mB[i] = '0; end
    mAf = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7: reset contents read back as zero
    busCycle(0, 1, 4'd3, 0, 1, 8'h00);
    check("R7", rdData, 8'h00);
    busCycle(0, 0, 4'd5, 0, 1, 8'h00);
    busCycle(0, 1, 4'd8, 0, 1, 8'h00);
    // R2/R3/R10: direct channel writes then reads
    busCycle(0, 1, 4'd2, 1, 0, 8'hA5);
    busCycle(0, 0, 4'd2, 1, 0, 8'h3C);
    busCycle(0, 1, 4'd2, 0, 1, 8'h00);
    check("R10", rdData, 8'hA5);
    busCycle(0, 0, 4'd2, 0, 1, 8'h00);
    // R1: idle write ignored, read back after
    busCycle(1, 1, 4'd2, 1, 0, 8'hFF);
    busCycle(1, 0, 4'd2, 0, 1, 8'h00);
    busCycle(0, 1, 4'd2, 0, 1, 8'h00);
    // R6: unmapped address ignored
    busCycle(0, 1, 4'd12, 1, 0, 8'h77);
    busCycle(0, 1, 4'd12, 0, 1, 8'h00);
    // R4: broadcast on, write through channel B pick reaches both
    busCycle(0, 0, 4'd8, 1, 0, 8'h01);
    busCycle(0, 0, 4'd8, 0, 1, 8'h00);
    busCycle(0, 1, 4'd8, 0, 1, 8'h00);
    busCycle(0, 0, 4'd6, 1, 0, 8'h5A);
    busCycle(0, 1, 4'd6, 0, 1, 8'h00);
    check("R4", rdData, 8'h5A);
    busCycle(0, 0, 4'd6, 0, 1, 8'h00);
    // R5: reads still follow pick in broadcast mode
    busCycle(0, 1, 4'd2, 0, 1, 8'h00);
    busCycle(0, 0, 4'd2, 0, 1, 8'h00);
    // R9: clash, write lands, read suppressed
    busCycle(0, 1, 4'd1, 1, 1, 8'hC3);
    busCycle(0, 0, 4'd1, 0, 1, 8'h00);
    busCycle(0, 0, 4'd8, 1, 0, 8'h00);
    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic s, ch, w, r;
      s  = ($urandom % 8) == 0;
      ch = 1'($urandom);
      w  = 1'($urandom);
      r  = 1'($urandom);
      d  = 8'($urandom);
      a  = (($urandom % 10) == 0) ? 4'd8 : 4'($urandom % 12);
      busCycle(s, ch, a, w, r, d);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule